// File: doc/BRIEF.md
# Discharge-Path Protection Controller

This block is the discharge-side sequencer of a two-cell battery protector. Its inputs are already-digitised comparator flags: an under-voltage flag per cell, an over-current flag, a short-circuit flag, a charger-present flag, the latched over-charge state from the neighbouring charge-side controller, and a test input. From these it drives the gate enable of the external discharge switch, a low-power standby request, and a two-bit selector that tells the analog section how to bias the load-minus node. Each fault must persist for its own number of clock cycles before it takes effect, and the fault then stays latched until its own release condition is met.

The controller is one state machine. It has six states:
- `ST_RUN`: normal operation.
- `ST_OC_HOLD`: an over-current is latched.
- `ST_SC_HOLD`: a short circuit is latched.
- `ST_OD_SLEEP`: cell under-voltage with standby.
- `ST_OD_WAKE`: a charger has been seen and the block waits for the cells to recover.
- `ST_OD_HOLD`: cell under-voltage without standby, because over-charge was already latched.

The transitions are:
- run→od (under-voltage timer expires).
- run→sc and oc→sc (short timer expires).
- run→oc (over-current timer expires).
- oc→od and sc→od (under-voltage timer expires while a current fault is held).
- oc→run and sc→run (current release timer expires).
- sleep→wake (charger present).
- wake→run and hold→run (under-voltage release timer expires).

Five delay timers feed the state machine, one for each detection or release condition. The test input cuts every timer to a short value except the short-circuit timer.

Top module: `dchg_guard`

## Requirements
- R1: After reset `dis_en` is 1, `standby` is 0 and `pull_sel` is 00. The bias selector encodes 00 as no bias, 01 as tie to the positive rail and 10 as tie to ground. The value 11 never appears.
- R2: If `od_c1` or `od_c2` is high for OD_DET_CYC consecutive rising edges, `dis_en` goes low at the last of those edges. A single low cycle before that point restarts the count.
- R3: When the under-voltage detection completes and `ovc_latched` is low, `standby` goes high and `pull_sel` becomes 01. If `ovc_latched` is high at that edge, `standby` stays 0 and `pull_sel` is still 01. That state returns to run, with no charger needed, once both cells have been clear for OD_REL_CYC edges.
- R4: Standby is left only at an edge where `chg_present` is high. The block then shows `standby`=0 and `pull_sel`=00. `dis_en` returns to 1 after both cell flags have been low for OD_REL_CYC edges.
- R5: If `oc_flag` is high for OC_DET_CYC edges, `dis_en` goes low with `pull_sel`=10. The block returns to run once `oc_flag` and `sc_flag` have both been low for OC_REL_CYC edges.
- R6: If `sc_flag` is high for SC_DET_CYC edges, `dis_en` goes low with `pull_sel`=10. This delay is the same whether `test_mode` is high or low.
- R7: An under-voltage detection that completes while an over-current is held replaces the ground tie with the rail tie (01) and enters standby.
- R8: Once under-voltage is latched, `oc_flag` and `sc_flag` have no effect: `standby` and `pull_sel`=01 are unchanged.
- R9: If `ovc_latched` is high when an over-current detection completes, `pull_sel` is 00 (released) while `dis_en` is low.
- R10: While `test_mode` is high, the under-voltage detection and release delays and the over-current detection and release delays all shrink to TEST_CYC edges.
- R11: If more than one detection completes at the same edge, under-voltage wins over short circuit, and short circuit wins over over-current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Delay-count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| od_c1 | input | 1 | Cell 1 under-voltage flag |
| od_c2 | input | 1 | Cell 2 under-voltage flag |
| oc_flag | input | 1 | Over-current flag |
| sc_flag | input | 1 | Short-circuit flag |
| chg_present | input | 1 | Charger connected (load-minus below the wake level) |
| ovc_latched | input | 1 | Over-charge latched by the charge-side controller |
| test_mode | input | 1 | Shortens the counted delays |
| dis_en | output | 1 | Discharge switch enable (1 = on) |
| standby | output | 1 | Low-power standby request |
| pull_sel | output | 2 | Load-minus bias: 00 none, 01 rail, 10 ground |

## Verification
The under-voltage detection and the over-current detection can expire on the same clock edge. To provoke this, the bench raises an under-voltage flag and raises the over-current flag exactly OD_DET_CYC−OC_DET_CYC cycles later, so both timers reach their limits together. The result counts as correct only if the block lands in standby with the rail tie and never passes through the ground tie. Random flag traffic then checks that the bias code stays legal and that standby is left only at an edge where a charger is present.

// File: rtl/dg_pkg.sv
package dg_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_OC_HOLD  = 3'd1,
        ST_SC_HOLD  = 3'd2,
        ST_OD_SLEEP = 3'd3,
        ST_OD_WAKE  = 3'd4,
        ST_OD_HOLD  = 3'd5
    } dg_state_e;

    typedef enum logic [1:0] {
        PULL_OFF = 2'b00,
        PULL_VDD = 2'b01,
        PULL_VSS = 2'b10
    } dg_pull_e;

endpackage

// File: rtl/dg_delay.sv
// Consecutive-cycle qualifier: done rises once run has been high for the
// selected number of edges; any low cycle clears the count.
module dg_delay #(
    parameter int unsigned LONG     = 4,
    parameter int unsigned TEST     = 2,
    parameter bit          CUTTABLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    output logic done
);
    localparam int unsigned CW = (LONG > 1) ? $clog2(LONG) : 1;
    localparam logic [CW-1:0] END_L = CW'(LONG - 1);
    localparam logic [CW-1:0] END_T = CW'(TEST - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb begin
        lim  = (CUTTABLE && fast) ? END_T : END_L;
        done = run && (cnt >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (cnt < lim)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dg_pull_sel.sv
// Maps the controller state to the load-minus bias code.
module dg_pull_sel
    import dg_pkg::*;
(
    input  dg_state_e st,
    input  logic      ovc_first,
    output dg_pull_e  pull
);
    always_comb begin
        unique case (st)
            ST_RUN:      pull = PULL_OFF;
            ST_OC_HOLD:  pull = ovc_first ? PULL_OFF : PULL_VSS;
            ST_SC_HOLD:  pull = PULL_VSS;
            ST_OD_SLEEP: pull = PULL_VDD;
            ST_OD_HOLD:  pull = PULL_VDD;
            ST_OD_WAKE:  pull = PULL_OFF;
            default:     pull = PULL_OFF;
        endcase
    end
endmodule

// File: rtl/dchg_guard.sv
module dchg_guard
    import dg_pkg::*;
#(
    parameter int unsigned OD_DET_CYC = 40,
    parameter int unsigned OD_REL_CYC = 8,
    parameter int unsigned OC_DET_CYC = 16,
    parameter int unsigned OC_REL_CYC = 8,
    parameter int unsigned SC_DET_CYC = 4,
    parameter int unsigned TEST_CYC   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       od_c1,
    input  logic       od_c2,
    input  logic       oc_flag,
    input  logic       sc_flag,
    input  logic       chg_present,
    input  logic       ovc_latched,
    input  logic       test_mode,
    output logic       dis_en,
    output logic       standby,
    output logic [1:0] pull_sel
);
    localparam int NT    = 5;
    localparam int T_ODD = 0;
    localparam int T_ODR = 1;
    localparam int T_OCD = 2;
    localparam int T_OCR = 3;
    localparam int T_SCD = 4;
    localparam int unsigned TLEN [NT] = '{OD_DET_CYC, OD_REL_CYC, OC_DET_CYC,
                                          OC_REL_CYC, SC_DET_CYC};
    localparam bit          TCUT [NT] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

    dg_state_e st, st_nx;
    dg_pull_e  pull;
    logic      ovc_first;
    logic      od_any;
    logic [NT-1:0] t_run;
    logic [NT-1:0] t_done;

    assign od_any = od_c1 | od_c2;

    // Timer run conditions, gated by the states in which each is meaningful
    always_comb begin
        t_run[T_ODD] = od_any && (st == ST_RUN || st == ST_OC_HOLD || st == ST_SC_HOLD);
        t_run[T_ODR] = !od_any && (st == ST_OD_WAKE || st == ST_OD_HOLD);
        t_run[T_OCD] = oc_flag && (st == ST_RUN);
        t_run[T_OCR] = !oc_flag && !sc_flag && (st == ST_OC_HOLD || st == ST_SC_HOLD);
        t_run[T_SCD] = sc_flag && (st == ST_RUN || st == ST_OC_HOLD);
    end

    for (genvar g = 0; g < NT; g++) begin : g_tmr
        dg_delay #(
            .LONG    (TLEN[g]),
            .TEST    (TEST_CYC),
            .CUTTABLE(TCUT[g])
        ) u_dly (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (t_run[g]),
            .fast (test_mode),
            .done (t_done[g])
        );
    end

    // Next-state: under-voltage outranks short, short outranks over-current
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_RUN: begin
                if (t_done[T_ODD])
                    st_nx = ovc_latched ? ST_OD_HOLD : ST_OD_SLEEP;
                else if (t_done[T_SCD])
                    st_nx = ST_SC_HOLD;
                else if (t_done[T_OCD])
                    st_nx = ST_OC_HOLD;
            end
            ST_OC_HOLD: begin
                if (t_done[T_ODD])
                    st_nx = ovc_latched ? ST_OD_HOLD : ST_OD_SLEEP;
                else if (t_done[T_SCD])
                    st_nx = ST_SC_HOLD;
                else if (t_done[T_OCR])
                    st_nx = ST_RUN;
            end
            ST_SC_HOLD: begin
                if (t_done[T_ODD])
                    st_nx = ovc_latched ? ST_OD_HOLD : ST_OD_SLEEP;
                else if (t_done[T_OCR])
                    st_nx = ST_RUN;
            end
            ST_OD_SLEEP: begin
                if (chg_present)
                    st_nx = ST_OD_WAKE;
            end
            ST_OD_WAKE, ST_OD_HOLD: begin
                if (t_done[T_ODR])
                    st_nx = ST_RUN;
            end
            default: st_nx = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_RUN;
            ovc_first <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == ST_RUN && st_nx == ST_OC_HOLD)
                ovc_first <= ovc_latched;
        end
    end

    dg_pull_sel u_pull (
        .st       (st),
        .ovc_first(ovc_first),
        .pull     (pull)
    );

    // Output decode
    always_comb begin
        dis_en   = (st == ST_RUN);
        standby  = (st == ST_OD_SLEEP);
        pull_sel = pull;
    end
endmodule

// File: rtl/dchg_guard_chk.sv
module dchg_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       od_c1,
    input logic       od_c2,
    input logic       oc_flag,
    input logic       sc_flag,
    input logic       chg_present,
    input logic       ovc_latched,
    input logic       dis_en,
    input logic       standby,
    input logic [1:0] pull_sel
);
    // R1: the bias code 11 never appears
    p_pull_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pull_sel != 2'b11);

    // R3: standby always comes with the rail tie and the switch off
    p_stby_pull_r3: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (pull_sel == 2'b01 && !dis_en));

    // R3: standby is never entered while over-charge is latched
    p_stby_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby) |-> $past(!ovc_latched));

    // R4: standby is left only at an edge where a charger is present
    p_stby_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(standby) |-> $past(chg_present));

    // R2: the switch turns off only while some fault flag is present
    p_disen_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dis_en) |-> $past(od_c1 || od_c2 || oc_flag || sc_flag));
endmodule

bind dchg_guard dchg_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .od_c1      (od_c1),
    .od_c2      (od_c2),
    .oc_flag    (oc_flag),
    .sc_flag    (sc_flag),
    .chg_present(chg_present),
    .ovc_latched(ovc_latched),
    .dis_en     (dis_en),
    .standby    (standby),
    .pull_sel   (pull_sel)
);

// File: tb/sim_dchg_guard.sv
module sim_dchg_guard;
    localparam time CLK_PERIOD = 10ns;
    localparam int  ODD = 40;
    localparam int  ODR = 8;
    localparam int  OCD = 16;
    localparam int  OCR = 8;
    localparam int  SCD = 4;
    localparam int  TST = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic od_c1, od_c2, oc_flag, sc_flag, chg_present, ovc_latched, test_mode;
    logic dis_en, standby;
    logic [1:0] pull_sel;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dchg_guard #(
        .OD_DET_CYC(ODD), .OD_REL_CYC(ODR), .OC_DET_CYC(OCD),
        .OC_REL_CYC(OCR), .SC_DET_CYC(SCD), .TEST_CYC(TST)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .od_c1(od_c1), .od_c2(od_c2),
        .oc_flag(oc_flag), .sc_flag(sc_flag), .chg_present(chg_present),
        .ovc_latched(ovc_latched), .test_mode(test_mode),
        .dis_en(dis_en), .standby(standby), .pull_sel(pull_sel)
    );

    // Expected output word {dis_en, standby, pull_sel}
    function automatic logic [3:0] pack(input logic d, input logic s, input logic [1:0] p);
        return {d, s, p};
    endfunction
    function automatic logic [3:0] exp_run();     return pack(1'b1, 1'b0, 2'b00); endfunction
    function automatic logic [3:0] exp_sleep();   return pack(1'b0, 1'b1, 2'b01); endfunction
    function automatic logic [3:0] exp_gnd();     return pack(1'b0, 1'b0, 2'b10); endfunction
    function automatic logic [3:0] exp_odhold();  return pack(1'b0, 1'b0, 2'b01); endfunction
    function automatic logic [3:0] exp_free();    return pack(1'b0, 1'b0, 2'b00); endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [3:0] expv);
        logic [3:0] act;
        act = pack(dis_en, standby, pull_sel);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, expv, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        od_c1 = 0; od_c2 = 0; oc_flag = 0; sc_flag = 0;
        chg_present = 0; ovc_latched = 0; test_mode = 0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic prev_stby, prev_chg;
        int unsigned seed_ret;
        do_reset();
        chk("R1 reset", exp_run());

        // R2 / R3: under-voltage on cell 1 after exactly ODD edges
        od_c1 = 1; step(ODD - 1); chk("R2 before limit", exp_run());
        step(1); chk("R3 standby entry", exp_sleep());
        // R4: cells recover but no charger -> remain in standby
        od_c1 = 0; step(50); chk("R4 no charger", exp_sleep());
        // R4: charger releases standby, then release delay
        chg_present = 1; step(1); chk("R4 wake", exp_free());
        step(ODR - 1); chk("R4 release pending", exp_free());
        step(1); chk("R4 release done", exp_run());

        // R2: a one-cycle dropout restarts the count
        do_reset();
        od_c2 = 1; step(30); od_c2 = 0; step(1); od_c2 = 1;
        step(ODD - 1); chk("R2 restart", exp_run());
        step(1); chk("R2 restart trip", exp_sleep());

        // R5: over-current detect and release
        do_reset();
        oc_flag = 1; step(OCD - 1); chk("R5 before limit", exp_run());
        step(1); chk("R5 trip", exp_gnd());
        oc_flag = 0; step(OCR - 1); chk("R5 release pending", exp_gnd());
        step(1); chk("R5 release", exp_run());

        // R6: short delay not cut by test mode
        do_reset();
        test_mode = 1; sc_flag = 1; step(SCD - 1); chk("R6 test not cut", exp_run());
        step(1); chk("R6 trip", exp_gnd());

        // R10: test mode cuts the under-voltage delay
        do_reset();
        test_mode = 1; od_c1 = 1; step(TST - 1); chk("R10 before cut limit", exp_run());
        step(1); chk("R10 cut trip", exp_sleep());

        // R7: over-current then under-voltage
        do_reset();
        oc_flag = 1; step(OCD); chk("R7 oc held", exp_gnd());
        od_c1 = 1; step(ODD - 1); chk("R7 still ground", exp_gnd());
        step(1); chk("R7 to standby", exp_sleep());

        // R8: current faults ignored once under-voltage is latched
        do_reset();
        od_c2 = 1; step(ODD); chk("R8 standby", exp_sleep());
        oc_flag = 1; sc_flag = 1; step(30); chk("R8 faults ignored", exp_sleep());

        // R3: over-charge latched first -> no standby, release without charger
        do_reset();
        ovc_latched = 1; od_c1 = 1; step(ODD); chk("R3 no standby", exp_odhold());
        od_c1 = 0; step(ODR - 1); chk("R3 release pending", exp_odhold());
        step(1); chk("R3 release", exp_run());

        // R9: over-charge latched first -> bias released during over-current
        do_reset();
        ovc_latched = 1; oc_flag = 1; step(OCD); chk("R9 released bias", exp_free());

        // R11: under-voltage and over-current expire at the same edge
        do_reset();
        od_c1 = 1; step(ODD - OCD); oc_flag = 1;
        step(OCD - 1); chk("R11 before tie", exp_run());
        step(1); chk("R11 priority", exp_sleep());

        // Random traffic with invariant checks (R1, R3, R4)
        do_reset();
        seed_ret = $urandom(32'd4242);
        prev_stby = standby; prev_chg = chg_present;
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 16) == 0) od_c1 = ~od_c1;
            if (($urandom % 32) == 0) od_c2 = ~od_c2;
            if (($urandom % 12) == 0) oc_flag = ~oc_flag;
            if (($urandom % 24) == 0) sc_flag = ~sc_flag;
            if (($urandom % 20) == 0) chg_present = ~chg_present;
            if (($urandom % 64) == 0) ovc_latched = ~ovc_latched;
            prev_chg = chg_present;
            step(1);
            total++;
            if (pull_sel == 2'b11) begin
                bad++; $display("FAIL R1: got pull %b expected not 11", pull_sel);
            end
            if (standby) begin
                total++;
                if (dis_en !== 1'b0 || pull_sel !== 2'b01) begin
                    bad++;
                    $display("FAIL R3: got dis %b pull %b expected 0 01", dis_en, pull_sel);
                end
            end
            if (prev_stby && !standby) begin
                total++;
                if (!prev_chg) begin
                    bad++; $display("FAIL R4: got exit with charger 0 expected 1");
                end
            end
            prev_stby = standby;
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule